// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves 18-bit words between two ports, A and B, one storage word per direction. Each direction has four controls of its own: a latch enable, a data clock, an active-low clock enable and an active-low output enable. Together they pick one of three behaviours for that direction:

- **Pass-through:** the output follows the input.
- **Hold:** the stored word is kept.
- **Edge capture:** the input is taken on a rising edge of the data clock.

The block runs on a fast system clock. It samples the latch enable and the data clock as levels. It finds a data-clock edge by comparing the current sample with the sample from the previous cycle.

Each output word comes from a register, so every change reaches the output port one system-clock cycle after the inputs that cause it are sampled. Each output has its own drive-enable flag next to its data bus. A wrapper at the pad level can turn each bus and flag into tri-state pins.

A contention flag warns when both directions are enabled to drive at the same time. Each direction still follows its own rules while the flag is raised.

Top module: `ubt_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` in the cycle after a system-clock edge equals the `a_in` value sampled at that edge. This holds whatever the levels of `ab_dclk` and `ab_cke_n`.
- R2: Capture in the A-to-B direction happens when all of the following hold at one system-clock edge:
  - `ab_le` is 0 and `ab_cke_n` is 0;
  - `ab_dclk` is sampled 1;
  - `ab_dclk` was sampled 0 at the previous edge.
  
  On such an edge the `a_in` value sampled there appears on `b_out` in the following cycle.
- R3: While `ab_le` is 0 and `ab_dclk` is held steady (low or high), `b_out` does not change, whatever `a_in` does.
- R4: While `ab_le` is 0 and `ab_cke_n` is 1, rising edges of `ab_dclk` are ignored and `b_out` keeps its value.
- R5: `b_drive` is the inverse of `ab_oe_n` and `a_drive` is the inverse of `ba_oe_n`. Both are combinational, including during reset. An output enable of 1 releases that port whatever its other controls are.
- R6: The B-to-A direction obeys R1 to R4 with `ba_le`, `ba_dclk`, `ba_cke_n`, `b_in` and `a_out`. It is independent of the A-to-B controls.
- R7: Suppose `ab_dclk` is already sampled 1 before `ab_le` falls and stays 1 afterwards. Then `b_out` keeps the last word passed through while `ab_le` was 1.
- R8: While `rst_n` is 0, `a_out` and `b_out` are zero. After reset the previous data-clock sample is taken as 0.
- R9: `contention` is 1 exactly when `ab_oe_n` and `ba_oe_n` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = pass-through) |
| ab_dclk | input | 1 | A-to-B data clock, sampled as a level |
| ab_cke_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = pass-through) |
| ba_dclk | input | 1 | B-to-A data clock, sampled as a level |
| ba_cke_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | 18 | Word driven toward port B |
| b_drive | output | 1 | Port B drive enable |
| a_out | output | 18 | Word driven toward port A |
| a_drive | output | 1 | Port A drive enable |
| contention | output | 1 | Both directions enabled to drive |

## Verification
The properties assume that the data clocks and latch enables are synchronous levels. They are sampled once per system-clock edge, and each data-clock phase lasts at least one system-clock cycle, so every edge shows up as a 0-then-1 pair of samples. The bench changes every control only at the falling system-clock edge and holds each data-clock phase for one or more whole cycles. Data-clock edge rules are checked only from the second post-reset edge onward, because the remembered sample only starts to track the input there. The bench keeps both data clocks low through reset, so the first post-reset comparison stays consistent.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Behaviour selected for one direction in one system-clock cycle
    typedef enum logic [1:0] {
        XFER_HOLD    = 2'd0,
        XFER_PASS    = 2'd1,
        XFER_CAPTURE = 2'd2
    } xfer_mode_e;

    // Control set owned by one direction
    typedef struct packed {
        logic le;
        logic dclk;
        logic cke_n;
        logic oe_n;
    } dir_ctrl_t;

endpackage

// File: rtl/ubt_mode_dec.sv
module ubt_mode_dec
    import ubt_pkg::*;
(
    input  logic       le,
    input  logic       cke_n,
    input  logic       clk_now,
    input  logic       clk_prev,
    output xfer_mode_e mode
);

    logic edge_seen;

    assign edge_seen = clk_now & ~clk_prev;

    always_comb begin
        if (le) begin
            mode = XFER_PASS;
        end else if (!cke_n && edge_seen) begin
            mode = XFER_CAPTURE;
        end else begin
            mode = XFER_HOLD;
        end
    end

endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  dir_ctrl_t    ctrl,
    output logic [W-1:0] dout,
    output logic         drive
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         clk_seen;
    } path_state_t;

    path_state_t st_d, st_q;
    xfer_mode_e  mode;

    ubt_mode_dec mode_dec_i (
        .le       (ctrl.le),
        .cke_n    (ctrl.cke_n),
        .clk_now  (ctrl.dclk),
        .clk_prev (st_q.clk_seen),
        .mode     (mode)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clk_seen = ctrl.dclk;
        case (mode)
            XFER_PASS,
            XFER_CAPTURE: st_d.word = din;
            default:      st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.word;
    assign drive = ~ctrl.oe_n;

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_dclk,
    input  logic         ab_cke_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_dclk,
    input  logic         ba_cke_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic         contention
);

    localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

    logic [W-1:0] src_w  [NDIR];
    logic [W-1:0] dst_w  [NDIR];
    logic         drv    [NDIR];
    dir_ctrl_t    ctl    [NDIR];

    assign src_w[0] = a_in;
    assign src_w[1] = b_in;
    assign ctl[0]   = '{le: ab_le, dclk: ab_dclk, cke_n: ab_cke_n, oe_n: ab_oe_n};
    assign ctl[1]   = '{le: ba_le, dclk: ba_dclk, cke_n: ba_cke_n, oe_n: ba_oe_n};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        ubt_dir_path #(.W(W)) path_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (src_w[g]),
            .ctrl  (ctl[g]),
            .dout  (dst_w[g]),
            .drive (drv[g])
        );
    end

    assign b_out      = dst_w[0];
    assign b_drive    = drv[0];
    assign a_out      = dst_w[1];
    assign a_drive    = drv[1];
    assign contention = drv[0] & drv[1];

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_dclk,
    input logic         ab_cke_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_dclk,
    input logic         ba_cke_n,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic         contention
);

    // High from the second post-reset edge: $past then sees post-reset samples
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_pass_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ab_le) |=> (b_out == $past(a_in)));

    p_capture_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ab_le && !ab_cke_n && ab_dclk && !$past(ab_dclk))
        |=> (b_out == $past(a_in)));

    p_steady_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ab_le && (ab_dclk == $past(ab_dclk))) |=> $stable(b_out));

    p_gated_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ab_le && ab_cke_n) |=> $stable(b_out));

    p_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drive != ab_oe_n) && (a_drive != ba_oe_n));

    p_pass_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ba_le) |=> (a_out == $past(b_in)));

    p_capture_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ba_le && !ba_cke_n && ba_dclk && !$past(ba_dclk))
        |=> (a_out == $past(b_in)));

    p_gated_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ba_le && (ba_cke_n || (ba_dclk == $past(ba_dclk))))
        |=> $stable(a_out));

    p_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        contention == (!ab_oe_n && !ba_oe_n));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) chk_i (.*);

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/1ps
module ubt_xcvr_tb_top;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         ab_oe_n, ab_le, ab_dclk, ab_cke_n;
    logic         ba_oe_n, ba_le, ba_dclk, ba_cke_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive, contention;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R8";

    // Reference model state
    logic [W-1:0] m_word [2];
    logic         m_prev [2];

    always #2.5 clk = ~clk;

    ubt_xcvr #(.W(W)) dut_i (.*);

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step_model(int d, logic le, logic dclk, logic cke_n, logic [W-1:0] din);
        if (le) m_word[d] = din;
        else if (!cke_n && dclk && !m_prev[d]) m_word[d] = din;
        m_prev[d] = dclk;
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_word[0] = '0; m_word[1] = '0; m_prev[0] = 1'b0; m_prev[1] = 1'b0;
        end else begin
            step_model(0, ab_le, ab_dclk, ab_cke_n, a_in);
            step_model(1, ba_le, ba_dclk, ba_cke_n, b_in);
        end
        @(negedge clk);
        chk(cur_req, b_out, m_word[0]);
        chk((cur_req == "R8") ? "R8" : "R6", a_out, m_word[1]);
        chk("R5", W'(b_drive), W'(!ab_oe_n));
        chk("R5", W'(a_drive), W'(!ba_oe_n));
        chk("R9", W'(contention), W'(!ab_oe_n && !ba_oe_n));
    endtask

    task automatic set_dir(int d, logic le, logic dclk, logic cke_n, logic [W-1:0] data);
        if (d == 0) begin
            ab_le = le; ab_dclk = dclk; ab_cke_n = cke_n; a_in = data;
        end else begin
            ba_le = le; ba_dclk = dclk; ba_cke_n = cke_n; b_in = data;
        end
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    function automatic logic [W-1:0] out_of(int d);
        return (d == 0) ? b_out : a_out;
    endfunction

    // Exercises R1..R4 and R7 on one direction
    task automatic run_dir(int d);
        logic [W-1:0] held;
        logic [W-1:0] last;
        cur_req = (d == 0) ? "R1" : "R6";
        for (int i = 0; i < 6; i++) begin
            last = rnd();
            set_dir(d, 1'b1, i[0], i[1], last);
            tick();
            chk((d == 0) ? "R1" : "R6", out_of(d), last);
        end
        // clock high before the latch enable falls (R7)
        cur_req = (d == 0) ? "R7" : "R6";
        last = rnd();
        set_dir(d, 1'b1, 1'b1, 1'b0, last);
        tick();
        held = last;
        for (int i = 0; i < 4; i++) begin
            set_dir(d, 1'b0, 1'b1, 1'b0, rnd());
            tick();
        end
        chk((d == 0) ? "R7" : "R6", out_of(d), held);
        // steady clock low (R3)
        cur_req = (d == 0) ? "R3" : "R6";
        for (int i = 0; i < 4; i++) begin
            set_dir(d, 1'b0, 1'b0, 1'b0, rnd());
            tick();
        end
        chk((d == 0) ? "R3" : "R6", out_of(d), held);
        // rising edges with clock enable active (R2)
        cur_req = (d == 0) ? "R2" : "R6";
        for (int i = 0; i < 5; i++) begin
            last = rnd();
            set_dir(d, 1'b0, 1'b1, 1'b0, last);
            tick();
            chk((d == 0) ? "R2" : "R6", out_of(d), last);
            held = last;
            set_dir(d, 1'b0, 1'b0, 1'b0, rnd());
            tick();
            chk((d == 0) ? "R3" : "R6", out_of(d), held);
        end
        // clock enable inactive (R4)
        cur_req = (d == 0) ? "R4" : "R6";
        for (int i = 0; i < 8; i++) begin
            set_dir(d, 1'b0, i[0], 1'b1, rnd());
            tick();
        end
        chk((d == 0) ? "R4" : "R6", out_of(d), held);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_oe_n = 1'b1; ab_le = 1'b0; ab_dclk = 1'b0; ab_cke_n = 1'b0;
        ba_oe_n = 1'b1; ba_le = 1'b0; ba_dclk = 1'b0; ba_cke_n = 1'b0;
        m_word[0] = '0; m_word[1] = '0; m_prev[0] = 1'b0; m_prev[1] = 1'b0;
        // R8: reset clears; R5: drive flags follow enables even in reset
        cur_req = "R8";
        a_in = 18'h3ffff; b_in = 18'h2aaaa; ab_le = 1'b1; ba_le = 1'b1;
        tick();
        ab_oe_n = 1'b0;
        tick();
        chk("R8", b_out, '0);
        chk("R8", a_out, '0);
        chk("R5", W'(b_drive), W'(1));
        @(negedge clk);
        ab_le = 1'b0; ba_le = 1'b0;
        rst_n = 1'b1;
        tick();

        run_dir(0);
        ba_oe_n = 1'b0;
        ab_oe_n = 1'b1;
        run_dir(1);

        // R9 / R5: all output-enable combinations
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin
            ab_oe_n = i[0]; ba_oe_n = i[1];
            tick();
            chk("R9", W'(contention), W'(i == 0));
        end
        // R1 with both directions transparent and contention raised
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;
        cur_req = "R1";
        for (int i = 0; i < 3; i++) begin
            a_in = rnd(); b_in = rnd(); ab_le = 1'b1; ba_le = 1'b1;
            tick();
            chk("R1", b_out, a_in);
            chk("R6", a_out, b_in);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule